// File: doc/BRIEF.md
# Floating-Point Minimum / Maximum Selector

This unit picks one of two IEEE-754 operands, `fs` and `ft`, according to a selection operation: the signed maximum, the signed minimum, the operand of larger magnitude, or the operand of smaller magnitude. Both binary32 and binary64 formats are handled. A precision select decides how the 64-bit operand buses are read. In single precision only the low 32 bits of each bus are used, and the result is returned in the low 32 bits with the upper half cleared. No arithmetic or rounding takes place. The result is always one of the inputs, possibly with a forced sign or a forced quiet bit.

Each operand is sorted into one of six classes: zero, subnormal, normal, infinity, quiet NaN or signalling NaN. The pair of classes, the signs and one unsigned comparison of the exponent-and-mantissa fields then decide which operand is returned. Fixed rules settle NaN pairs, signed zeros, opposite infinities and equal magnitudes of opposite sign, so the result never depends on operand order by chance. A signalling NaN raises an invalid-operation flag. In that case the returned value is the offending NaN with its quiet bit set.

The result and the flag are registered. They appear one clock after a request is presented with `inValid`.

Top module: `fpmm_unit`

## Requirements
- R1: When both operands are quiet NaNs and neither is signalling, the result is the `fs` word for every operation.
- R2: When exactly one operand is a quiet NaN and the other is a zero, subnormal, normal or infinity, the numeric operand is returned.
- R3: When both operands are zeros, MAX and MAXA return a zero whose sign is the AND of the two signs, and MIN and MINA return a zero whose sign is the OR of the two signs.
- R4: MAX returns the operand with the greater signed value and MIN the lesser one, including pairs that are both negative (MAX of -5.0 and -7.0 is -5.0).
- R5: MAXA returns the operand with the larger magnitude and MINA the one with the smaller magnitude. Magnitude is the unsigned value of the exponent field followed by the mantissa field, so subnormals, zeros and infinities order correctly among finite values.
- R6: For MAXA and MINA with two infinities, MAXA returns an infinity whose sign is the AND of the signs, and MINA one whose sign is the OR of the signs.
- R7: For MAXA and MINA with equal magnitudes and opposite signs, MAXA returns the positive operand and MINA the negative one.
- R8: A signalling NaN (exponent all ones, mantissa nonzero, mantissa MSB clear) in either operand sets `invalidFlag`. The result is that NaN with its mantissa MSB forced to 1, and `fs` is chosen when both operands are signalling. A quiet NaN has exponent all ones and mantissa MSB set.
- R9: With `isDouble` = 0, only bits [31:0] of each operand are used, the upper 32 operand bits have no effect, and `result[63:32]` is zero. With `isDouble` = 1 the full 64-bit words are used.
- R10: `outValid` is high exactly in the cycle after a cycle with `inValid` high. `result` and `invalidFlag` update only on such a request. After reset, `outValid`, `result` and `invalidFlag` are all zero.
- R11: `opSel` encodes 0 = MAX, 1 = MIN, 2 = MAXA, 3 = MINA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request strobe for the current operands |
| opSel | input | 2 | Operation: 0 MAX, 1 MIN, 2 MAXA, 3 MINA |
| isDouble | input | 1 | 1 selects binary64, 0 selects binary32 in bits [31:0] |
| fsIn | input | 64 | First operand (fs) |
| ftIn | input | 64 | Second operand (ft) |
| outValid | output | 1 | Result valid, one cycle after the request |
| result | output | 64 | Selected operand; single results sit in bits [31:0] |
| invalidFlag | output | 1 | Invalid-operation flag, set by a signalling NaN input |

## Verification
The bench builds the unit with its default format parameters: 8/23 exponent/mantissa bits for single and 11/52 for double. This lets one reference model cover both standard formats through the same precision-select input. Fixed vectors exercise each class-pair rule in both precisions:
- the signed-zero and opposite-infinity sign rules,
- equal magnitudes with opposite signs,
- signalling-NaN quieting with `fs` priority.

A long pseudo-random run then pairs special values, subnormals, sign-flipped copies of the same magnitude and random normals, with junk in the unused upper half of single-precision words. This reaches tie and ordering corners that the hand-picked vectors miss.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

  typedef enum logic [1:0] {
    OP_MAX  = 2'd0,
    OP_MIN  = 2'd1,
    OP_MAXA = 2'd2,
    OP_MINA = 2'd3
  } fpOp_e;

  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_SUB  = 3'd1,
    CL_NORM = 3'd2,
    CL_INF  = 3'd3,
    CL_QNAN = 3'd4,
    CL_SNAN = 3'd5
  } fpClass_e;

  // datapath -> control: what the operands look like
  typedef struct packed {
    fpClass_e fsCls;
    fpClass_e ftCls;
    logic     fsSign;
    logic     ftSign;
    logic     magLess;   // |fs| < |ft|
    logic     magEqual;  // |fs| == |ft|
  } opStatus_t;

  // control -> datapath: how to build the result
  typedef struct packed {
    logic pickFt;
    logic forceSign;
    logic signVal;
    logic quieten;
    logic invalid;
  } pickStrobe_t;

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
  import fpmm_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int WORD_W = 1 + EXP_W + MAN_W
) (
  input  logic [WORD_W-1:0]  word,
  output fpClass_e           cls,
  output logic               sign,
  output logic [WORD_W-2:0]  mag
);
  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;

  assign expField = word[MAN_W +: EXP_W];
  assign manField = word[MAN_W-1:0];
  assign sign     = word[WORD_W-1];
  assign mag      = word[WORD_W-2:0];

  always_comb begin
    if (&expField) begin
      if (manField == '0)          cls = CL_INF;
      else if (manField[MAN_W-1])  cls = CL_QNAN;
      else                         cls = CL_SNAN;
    end else if (expField == '0) begin
      cls = (manField == '0) ? CL_ZERO : CL_SUB;
    end else begin
      cls = CL_NORM;
    end
  end
endmodule

// File: rtl/fpmm_control.sv
module fpmm_control
  import fpmm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  opSel,
  input  opStatus_t   status,
  output pickStrobe_t strobe
);
  fpOp_e op;
  logic  fsSig, ftSig, fsQui, ftQui;
  logic  bothZero, bothInf, maxFam, magFam, ftGreater;

  assign op       = fpOp_e'(opSel);
  assign fsSig    = status.fsCls == CL_SNAN;
  assign ftSig    = status.ftCls == CL_SNAN;
  assign fsQui    = status.fsCls == CL_QNAN;
  assign ftQui    = status.ftCls == CL_QNAN;
  assign bothZero = (status.fsCls == CL_ZERO) && (status.ftCls == CL_ZERO);
  assign bothInf  = (status.fsCls == CL_INF) && (status.ftCls == CL_INF);
  assign maxFam   = (op == OP_MAX) || (op == OP_MAXA);
  assign magFam   = (op == OP_MAXA) || (op == OP_MINA);

  // signed ordering: ft strictly greater than fs (same-sign case)
  assign ftGreater = status.fsSign ? (!status.magLess && !status.magEqual)
                                   : status.magLess;

  always_comb begin
    strobe = '0;
    if (fsSig || ftSig) begin
      strobe.invalid = 1'b1;
      strobe.quieten = 1'b1;
      strobe.pickFt  = !fsSig;
    end else if (fsQui && ftQui) begin
      strobe.pickFt = 1'b0;
    end else if (fsQui || ftQui) begin
      strobe.pickFt = fsQui;
    end else if (bothZero || (magFam && bothInf)) begin
      strobe.forceSign = 1'b1;
      strobe.signVal   = maxFam ? (status.fsSign & status.ftSign)
                                : (status.fsSign | status.ftSign);
    end else if (magFam) begin
      if (status.magEqual)
        strobe.pickFt = maxFam ? (status.fsSign && !status.ftSign)
                               : (!status.fsSign && status.ftSign);
      else
        strobe.pickFt = maxFam ? status.magLess : !status.magLess;
    end else if (status.fsSign != status.ftSign) begin
      strobe.pickFt = maxFam ? status.fsSign : status.ftSign;
    end else begin
      strobe.pickFt = maxFam ? ftGreater : (!ftGreater && !status.magEqual);
    end
  end

  // R1: a quiet-NaN pair always yields fs
  assert_qnan_pair_fs_R1: assert property (@(posedge clk) disable iff (!rstN)
    (fsQui && ftQui) |-> !strobe.pickFt && !strobe.invalid);

  // R2: lone quiet NaN never selected
  assert_lone_qnan_R2: assert property (@(posedge clk) disable iff (!rstN)
    (fsQui != ftQui) && !fsSig && !ftSig |-> (strobe.pickFt == fsQui));

  // R3: opposite-sign zeros: max family positive, min family negative
  assert_zero_sign_R3: assert property (@(posedge clk) disable iff (!rstN)
    bothZero && (status.fsSign != status.ftSign) |-> strobe.forceSign && (strobe.signVal == !maxFam));

  // R8: signalling NaN always flags and quietens
  assert_snan_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fsSig || ftSig) |-> strobe.invalid && strobe.quieten && (strobe.pickFt == !fsSig));
endmodule

// File: rtl/fpmm_datapath.sv
module fpmm_datapath
  import fpmm_pkg::*;
#(
  parameter int SGL_EXP = 8,
  parameter int SGL_MAN = 23,
  parameter int DBL_EXP = 11,
  parameter int DBL_MAN = 52,
  localparam int SGL_W = 1 + SGL_EXP + SGL_MAN,
  localparam int DBL_W = 1 + DBL_EXP + DBL_MAN
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             isDouble,
  input  logic [DBL_W-1:0] fsIn,
  input  logic [DBL_W-1:0] ftIn,
  input  pickStrobe_t      strobe,
  output opStatus_t        status,
  output logic             outValid,
  output logic [DBL_W-1:0] result,
  output logic             invalidFlag
);
  localparam int SGL_MAG = SGL_W - 1;
  localparam int DBL_MAG = DBL_W - 1;
  localparam int N_OPND  = 2;

  logic [DBL_W-1:0]   rawArr  [N_OPND];
  logic [DBL_W-1:0]   wordArr [N_OPND];
  logic [DBL_MAG-1:0] magArr  [N_OPND];
  fpClass_e           clsArr  [N_OPND];
  logic               signArr [N_OPND];
  logic [DBL_W-1:0]   picked;
  logic               dblQ;

  assign rawArr[0] = fsIn;
  assign rawArr[1] = ftIn;

  for (genvar g = 0; g < N_OPND; g++) begin : gOpnd
    fpClass_e           sCls, dCls;
    logic               sSgn, dSgn;
    logic [SGL_MAG-1:0] sMag;
    logic [DBL_MAG-1:0] dMag;

    fpmm_classify #(.EXP_W(SGL_EXP), .MAN_W(SGL_MAN)) uSgl (
      .word(rawArr[g][SGL_W-1:0]), .cls(sCls), .sign(sSgn), .mag(sMag));
    fpmm_classify #(.EXP_W(DBL_EXP), .MAN_W(DBL_MAN)) uDbl (
      .word(rawArr[g]), .cls(dCls), .sign(dSgn), .mag(dMag));

    assign clsArr[g]  = isDouble ? dCls : sCls;
    assign signArr[g] = isDouble ? dSgn : sSgn;
    assign magArr[g]  = isDouble ? dMag : DBL_MAG'(sMag);
    assign wordArr[g] = isDouble ? rawArr[g] : DBL_W'(rawArr[g][SGL_W-1:0]);
  end

  assign status.fsCls    = clsArr[0];
  assign status.ftCls    = clsArr[1];
  assign status.fsSign   = signArr[0];
  assign status.ftSign   = signArr[1];
  assign status.magLess  = magArr[0] < magArr[1];
  assign status.magEqual = magArr[0] == magArr[1];

  always_comb begin
    picked = strobe.pickFt ? wordArr[1] : wordArr[0];
    if (isDouble) begin
      if (strobe.forceSign) picked[DBL_W-1]   = strobe.signVal;
      if (strobe.quieten)   picked[DBL_MAN-1] = 1'b1;
    end else begin
      if (strobe.forceSign) picked[SGL_W-1]   = strobe.signVal;
      if (strobe.quieten)   picked[SGL_MAN-1] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      result      <= '0;
      invalidFlag <= 1'b0;
      dblQ        <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result      <= picked;
        invalidFlag <= strobe.invalid;
        dblQ        <= isDouble;
      end
    end
  end

  // R10: one-cycle latency on the valid strobe
  assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R9: single results leave the upper half clear
  assert_single_upper_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !dblQ |-> result[DBL_W-1:SGL_W] == '0);

  // R8: a flagged result is a quiet NaN of its precision
  assert_invalid_qnan_R8: assert property (@(posedge clk) disable iff (!rstN)
    invalidFlag |-> (dblQ ? ((&result[DBL_W-2 -: DBL_EXP]) && result[DBL_MAN-1])
                          : ((&result[SGL_W-2 -: SGL_EXP]) && result[SGL_MAN-1])));
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
  import fpmm_pkg::*;
#(
  parameter int SGL_EXP = 8,
  parameter int SGL_MAN = 23,
  parameter int DBL_EXP = 11,
  parameter int DBL_MAN = 52,
  localparam int DBL_W = 1 + DBL_EXP + DBL_MAN
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [1:0]       opSel,
  input  logic             isDouble,
  input  logic [DBL_W-1:0] fsIn,
  input  logic [DBL_W-1:0] ftIn,
  output logic             outValid,
  output logic [DBL_W-1:0] result,
  output logic             invalidFlag
);
  opStatus_t   status;
  pickStrobe_t strobe;

  fpmm_control uCtrl (
    .clk(clk), .rstN(rstN), .opSel(opSel), .status(status), .strobe(strobe));

  fpmm_datapath #(
    .SGL_EXP(SGL_EXP), .SGL_MAN(SGL_MAN), .DBL_EXP(DBL_EXP), .DBL_MAN(DBL_MAN)
  ) uData (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isDouble(isDouble),
    .fsIn(fsIn), .ftIn(ftIn), .strobe(strobe), .status(status),
    .outValid(outValid), .result(result), .invalidFlag(invalidFlag));
endmodule

// File: tb/sim_fpmm_unit.sv
module sim_fpmm_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic        isDouble = 1'b0;
  logic [63:0] fsIn = '0;
  logic [63:0] ftIn = '0;
  logic        outValid;
  logic [63:0] result;
  logic        invalidFlag;

  int errs = 0;
  int checks = 0;
  bit finished = 0;

  logic [65:0] expQ[$];   // {valid, invalid, result}
  string       tagQ[$];

  always #2 clk = ~clk;   // 250 MHz

  fpmm_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel), .isDouble(isDouble),
    .fsIn(fsIn), .ftIn(ftIn), .outValid(outValid), .result(result), .invalidFlag(invalidFlag));

  // behavioural reference: returns {invalid, result}
  function automatic logic [64:0] refModel(input int op, input bit dbl,
                                           input logic [63:0] a, input logic [63:0] b);
    int mw = dbl ? 52 : 23;
    int ew = dbl ? 11 : 8;
    logic [63:0] wa = dbl ? a : {32'h0, a[31:0]};
    logic [63:0] wb = dbl ? b : {32'h0, b[31:0]};
    logic [63:0] sgn = dbl ? 64'h8000_0000_0000_0000 : 64'h8000_0000;
    logic [63:0] qb = 64'h1 << (mw - 1);
    logic [63:0] em = ((64'h1 << ew) - 1) << mw;
    logic [63:0] mm = (64'h1 << mw) - 1;
    logic [63:0] magA = wa & ~sgn;
    logic [63:0] magB = wb & ~sgn;
    bit sa = (wa & sgn) != 0;
    bit sb = (wb & sgn) != 0;
    bit nanA = ((wa & em) == em) && ((wa & mm) != 0);
    bit nanB = ((wb & em) == em) && ((wb & mm) != 0);
    bit sigA = nanA && ((wa & qb) == 0);
    bit sigB = nanB && ((wb & qb) == 0);
    bit maxFam = (op == 0) || (op == 2);
    longint ka = sa ? -longint'(magA) : longint'(magA);
    longint kb = sb ? -longint'(magB) : longint'(magB);
    if (sigA) return {1'b1, wa | qb};
    if (sigB) return {1'b1, wb | qb};
    if (nanA && nanB) return {1'b0, wa};
    if (nanA) return {1'b0, wb};
    if (nanB) return {1'b0, wa};
    if (magA == 0 && magB == 0)
      return {1'b0, (maxFam ? (sa & sb) : (sa | sb)) ? sgn : 64'h0};
    if (op >= 2 && magA == em && magB == em)
      return {1'b0, em | ((maxFam ? (sa & sb) : (sa | sb)) ? sgn : 64'h0)};
    case (op)
      0: return {1'b0, (kb > ka) ? wb : wa};
      1: return {1'b0, (kb < ka) ? wb : wa};
      2: begin
        if (magA != magB) return {1'b0, (magB > magA) ? wb : wa};
        return {1'b0, (sa && !sb) ? wb : wa};
      end
      default: begin
        if (magA != magB) return {1'b0, (magB < magA) ? wb : wa};
        return {1'b0, (!sa && sb) ? wb : wa};
      end
    endcase
  endfunction

  task automatic checkOut();
    logic [65:0] e;
    string t;
    if (expQ.size() == 0) return;
    e = expQ.pop_front();
    t = tagQ.pop_front();
    checks++;
    if (outValid !== e[65]) begin
      errs++;
      $display("FAIL %s R10 outValid got %0b exp %0b", t, outValid, e[65]);
    end
    if (e[65]) begin
      checks += 2;
      if (result !== e[63:0]) begin
        errs++;
        $display("FAIL %s result got %h exp %h", t, result, e[63:0]);
      end
      if (invalidFlag !== e[64]) begin
        errs++;
        $display("FAIL %s invalidFlag got %0b exp %0b", t, invalidFlag, e[64]);
      end
    end
  endtask

  task automatic drive(input bit v, input int op, input bit dbl,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    logic [64:0] r;
    @(negedge clk);
    checkOut();
    inValid  = v;
    opSel    = 2'(op);
    isDouble = dbl;
    fsIn     = a;
    ftIn     = b;
    r = refModel(op, dbl, a, b);
    expQ.push_back({v, r});
    tagQ.push_back(tag);
  endtask

  function automatic logic [63:0] pickVal(input bit dbl, input int sel, input logic [63:0] rnd);
    logic [63:0] v;
    if (dbl) begin
      case (sel)
        0: v = 64'h0;
        1: v = 64'h7FF0_0000_0000_0000;
        2: v = 64'h7FF8_0000_0000_0000 | (rnd & 64'hFFFF);
        3: v = 64'h7FF0_0000_0000_0001 | (rnd & 64'hFF00);
        4: v = rnd & 64'h000F_FFFF_FFFF_FFFF;
        default: v = {1'b0, 11'h3F0 + 11'(rnd[55:52]), rnd[51:0]};
      endcase
      if (rnd[63]) v[63] = 1'b1;
    end else begin
      case (sel)
        0: v = 64'h0;
        1: v = 64'h7F80_0000;
        2: v = 64'h7FC0_0000 | (rnd & 64'hFFFF);
        3: v = 64'h7F80_0001 | (rnd & 64'hFF00);
        4: v = rnd & 64'h007F_FFFF;
        default: v = {32'h0, 1'b0, 8'h78 + 8'(rnd[26:23]), rnd[22:0]};
      endcase
      if (rnd[31]) v[31] = 1'b1;
      v[63:32] = rnd[47:16];   // junk in the unused half (R9)
    end
    return v;
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (outValid !== 1'b0 || result !== 64'h0 || invalidFlag !== 1'b0) begin
      errs++;
      $display("FAIL R10 reset state got %0b/%h/%0b exp 0/0/0", outValid, result, invalidFlag);
    end
    rstN = 1'b1;

    // R1 both quiet NaN -> fs; R11 all op codes
    for (int op = 0; op < 4; op++) begin
      drive(1, op, 0, 64'h7FC0_0001, 64'h7FC0_0002, "R1_sgl");
      drive(1, op, 1, 64'h7FF8_0000_0000_0001, 64'h7FF8_0000_0000_0002, "R1_dbl");
    end
    // R2 one quiet NaN
    drive(1, 0, 0, 64'h7FC0_0000, 64'hC0A0_0000, "R2_fsnan");
    drive(1, 3, 1, 64'h4008_0000_0000_0000, 64'h7FF8_0000_0000_0003, "R2_ftnan");
    // R3 signed zeros
    for (int op = 0; op < 4; op++) begin
      drive(1, op, 0, 64'h0, 64'h8000_0000, "R3_p_n");
      drive(1, op, 0, 64'h8000_0000, 64'h0, "R3_n_p");
      drive(1, op, 1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, "R3_n_n");
    end
    // R4 both negative: MAX(-5,-7) = -5, MIN = -7
    drive(1, 0, 0, 64'hC0A0_0000, 64'hC0E0_0000, "R4_max_neg");
    drive(1, 1, 0, 64'hC0A0_0000, 64'hC0E0_0000, "R4_min_neg");
    drive(1, 0, 1, 64'hC01C_0000_0000_0000, 64'hC014_0000_0000_0000, "R4_max_neg_dbl");
    drive(1, 1, 0, 64'h40A0_0000, 64'hC0E0_0000, "R4_min_mixed");
    // R5 magnitude with subnormals and infinity
    drive(1, 2, 0, 64'h8000_0100, 64'h0000_0010, "R5_maxa_sub");
    drive(1, 3, 0, 64'h8000_0100, 64'h0000_0010, "R5_mina_sub");
    drive(1, 3, 0, 64'h0, 64'hFF80_0000, "R5_mina_zero_inf");
    drive(1, 3, 1, 64'h7FF0_0000_0000_0000, 64'hC014_0000_0000_0000, "R5_mina_inf_fin");
    drive(1, 2, 1, 64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000, "R5_maxa_sub_zero");
    // R6 opposite infinities
    drive(1, 2, 0, 64'h7F80_0000, 64'hFF80_0000, "R6_maxa_inf");
    drive(1, 3, 0, 64'h7F80_0000, 64'hFF80_0000, "R6_mina_inf");
    drive(1, 2, 1, 64'hFFF0_0000_0000_0000, 64'h7FF0_0000_0000_0000, "R6_maxa_inf_dbl");
    // R7 equal magnitude, opposite sign
    drive(1, 2, 0, 64'hC040_0000, 64'h4040_0000, "R7_maxa");
    drive(1, 3, 0, 64'hC040_0000, 64'h4040_0000, "R7_mina");
    drive(1, 3, 1, 64'h4008_0000_0000_0000, 64'hC008_0000_0000_0000, "R7_mina_dbl");
    // R8 signalling NaN
    drive(1, 0, 0, 64'h7F80_0001, 64'h4040_0000, "R8_fs_snan");
    drive(1, 1, 1, 64'h4008_0000_0000_0000, 64'hFFF0_0000_0000_0005, "R8_ft_snan");
    drive(1, 2, 0, 64'h7F80_0002, 64'h7F80_0003, "R8_both_snan");
    drive(1, 3, 0, 64'h7FC0_0000, 64'h7F80_0004, "R8_q_and_s");
    // R9 junk in upper half of single words
    drive(1, 0, 0, 64'hFFFF_FFFF_40A0_0000, 64'h1234_5678_C0E0_0000, "R9_junk");
    drive(1, 1, 0, 64'h7FF8_0000_3F80_0000, 64'hDEAD_BEEF_4000_0000, "R9_junk2");
    // R10 idle cycles: no valid, result held
    drive(0, 0, 0, 64'h0, 64'h0, "R10_idle");
    drive(0, 1, 1, 64'h7FF0_0000_0000_0001, 64'h0, "R10_idle2");

    // randomized sweep (all requirements)
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] ra, rb, a, b;
      bit dbl;
      int op;
      ra  = {$urandom, $urandom};
      rb  = {$urandom, $urandom};
      dbl = ra[7];
      op  = int'(rb[1:0]);
      a = pickVal(dbl, int'(ra[10:8]), ra);
      b = pickVal(dbl, int'(rb[10:8]), rb);
      if (rb[12:11] == 2'b00) b = dbl ? (a ^ 64'h8000_0000_0000_0000) : (a ^ 64'h8000_0000);
      if (rb[12:11] == 2'b01) b = a;
      drive(1, op, dbl, a, b, "rand_R4_R5_R7");
    end
    drive(0, 0, 0, 64'h0, 64'h0, "drain");
    @(negedge clk);
    checkOut();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule